// File: doc/BRIEF.md
# SPI Digital Potentiometer Controller

This block is the digital side of a one- or two-channel, 256-step potentiometer. A host writes 16-bit frames over a serial link with an active-low chip select, a serial clock and a data input. Each frame carries an operation, a channel mask and an 8-bit wiper code. The block holds one wiper code per channel, drives those codes to the analog switches, and raises a per-channel "terminal A open" output. While that output is high, the analog side disconnects terminal A and ties the wiper to terminal B.

All serial pins and both control pins are sampled by the block's own system clock through two-flop synchronizers. The serial clock may idle low or high, because only its rising edges inside a selected window count. The serial output presents the bit that was shifted in sixteen rising edges earlier. Several parts can therefore share one chip select, and a 32-bit burst leaves the first 16 bits in the next part of the chain. Power-on reset and the active-low reset pin both return the wipers to mid-scale. The active-low shutdown pin forces every channel open for as long as it is held low.

Top module: `digipot_ctrl`

## Requirements
- R1: After power-on reset (`rst_n` low) every wiper code is 80h and every `term_a_open` bit is 0.
- R2: Data on `si` is captured on each rising edge of `sck` while `cs_n` is low, most significant bit first. This holds whether `sck` idles low or idles high when `cs_n` falls.
- R3: A frame is interpreted from its last 16 bits, as follows. Bits [13:12] hold the operation: 01 is write, 10 is shutdown, and 00 and 11 do nothing. Bit 8 selects channel 0 and bit 9 selects channel 1; both may be set together. Bits [7:0] hold the wiper code.
- R4: A frame takes effect only when `cs_n` rises after a non-zero multiple of 16 rising `sck` edges. Any other count leaves every wiper code and shutdown state unchanged.
- R5: A write frame loads the code into each selected channel's wiper and leaves unselected channels unchanged.
- R6: A shutdown frame sets `term_a_open` for each selected channel and does not change its wiper code.
- R7: A write frame to a channel in software shutdown updates the code and clears that channel's software shutdown.
- R8: While `shdn_n` is low, every `term_a_open` bit is 1, and write frames still update the codes. When `shdn_n` is released, each bit returns to its channel's software shutdown state.
- R9: While `rs_n` is low, every wiper code is 80h and software shutdown is cleared. A frame that completes during this time has no effect.
- R10: `so` shows the bit captured 16 rising `sck` edges earlier. After a 32-edge burst, the first 16 bits appear on `so` during edges 17 to 32.
- R11: Frames with operation 00 or 11 change no wiper code and no shutdown state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, samples all pins |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out for chaining |
| rs_n | input | 1 | Reset pin, active low, wipers to mid-scale |
| shdn_n | input | 1 | Shutdown pin, active low, all channels |
| wiper_code | output | 8*NCH | Wiper codes, channel 0 in bits [7:0] |
| term_a_open | output | NCH | Per-channel shutdown state to analog switches |

## Verification
The bench targets frame lengths just below and above 16 (15, 17, 31) and a multiple (48). A design that counted bits wrongly would commit on one of these counts, or drop the last 16 bits of a long burst. It writes a channel that is already in software shutdown and checks that the channel comes back at the new code. A design that ignored writes during shutdown, or failed to clear the flag, would leave the old code or keep terminal A open. It holds the shutdown pin low across writes and then releases it, and pulses the reset pin around a completed frame. A wrong priority would show up either as a lost write or as a write that survives the reset. Random frames in both clock idle levels are compared against a bench model. The serial output of every 32-bit burst is compared against the first word sent.

// File: rtl/digipot_pkg.sv
package digipot_pkg;
  localparam int FRAME_W  = 16;
  localparam int CODE_W   = 8;
  localparam int CNT_W    = $clog2(FRAME_W);
  localparam int OP_LSB   = 12;
  localparam int SEL_LSB  = 8;
  localparam int SEL_W    = 2;
  localparam logic [CODE_W-1:0] MID_CODE = 8'h80;

  typedef enum logic [1:0] {
    OP_IDLE0 = 2'b00,
    OP_WRITE = 2'b01,
    OP_SHUT  = 2'b10,
    OP_IDLE3 = 2'b11
  } op_e;

  function automatic op_e frame_op(input logic [FRAME_W-1:0] f);
    return op_e'(f[OP_LSB +: 2]);
  endfunction

  function automatic logic [SEL_W-1:0] frame_sel(input logic [FRAME_W-1:0] f);
    return f[SEL_LSB +: SEL_W];
  endfunction

  function automatic logic [CODE_W-1:0] frame_code(input logic [FRAME_W-1:0] f);
    return f[CODE_W-1:0];
  endfunction

  // a frame counts only after a non-zero whole number of words
  function automatic logic len_ok(input logic seen, input logic [CNT_W-1:0] cnt);
    return seen && (cnt == '0);
  endfunction
endpackage

// File: rtl/serial_rx.sv
module serial_rx
  import digipot_pkg::*;
#(
  parameter int FW = FRAME_W,
  localparam int CW = $clog2(FW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sck,
  input  logic          si,
  output logic          so,
  output logic [FW-1:0] frame,
  output logic          commit_evt
);
  logic [1:0] cs_m, sck_m, si_m;
  logic       cs_d, sck_d;
  logic       cs_s, sck_s, si_s;
  logic       shift_evt, close_evt;
  logic [FW-1:0] shreg;
  logic [CW-1:0] bitcnt;
  logic          seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_m  <= 2'b11;
      sck_m <= 2'b00;
      si_m  <= 2'b00;
      cs_d  <= 1'b1;
      sck_d <= 1'b0;
    end else begin
      cs_m  <= {cs_m[0], cs_n};
      sck_m <= {sck_m[0], sck};
      si_m  <= {si_m[0], si};
      cs_d  <= cs_s;
      sck_d <= sck_s;
    end
  end

  assign cs_s  = cs_m[1];
  assign sck_s = sck_m[1];
  assign si_s  = si_m[1];

  assign shift_evt  = sck_s && !sck_d && !cs_s;
  assign close_evt  = cs_s && !cs_d;
  assign commit_evt = close_evt && len_ok(seen, bitcnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      bitcnt <= '0;
      seen   <= 1'b0;
    end else if (close_evt) begin
      bitcnt <= '0;
      seen   <= 1'b0;
    end else if (shift_evt) begin
      shreg  <= {shreg[FW-2:0], si_s};
      bitcnt <= bitcnt + 1'b1;
      seen   <= 1'b1;
    end
  end

  assign frame = shreg;
  assign so    = shreg[FW-1];

  // R4
  idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && cs_d) |=> $stable(bitcnt));

  // R2
  shift_only_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && cs_d) |=> $stable(shreg));
endmodule

// File: rtl/cmd_decode.sv
module cmd_decode
  import digipot_pkg::*;
#(
  parameter int NCH = 2,
  parameter int FW  = FRAME_W
) (
  input  logic [FW-1:0]     frame,
  input  logic              commit_evt,
  output logic [NCH-1:0]    wr_hit,
  output logic [NCH-1:0]    off_hit,
  output logic [CODE_W-1:0] code
);
  op_e              op;
  logic [SEL_W-1:0] sel;

  assign op   = frame_op(frame);
  assign sel  = frame_sel(frame);
  assign code = frame_code(frame);

  for (genvar i = 0; i < NCH; i++) begin : g_hit
    assign wr_hit[i]  = commit_evt && (op == OP_WRITE) && sel[i];
    assign off_hit[i] = commit_evt && (op == OP_SHUT)  && sel[i];
  end

  // R11
  idle_op_chk: assert property (@(posedge commit_evt)
    (op == OP_IDLE0 || op == OP_IDLE3) |-> (wr_hit == '0 && off_hit == '0));
endmodule

// File: rtl/wiper_chan.sv
module wiper_chan
  import digipot_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_rst,
  input  logic              hw_off,
  input  logic              wr_hit,
  input  logic              off_hit,
  input  logic [CODE_W-1:0] code,
  output logic [CODE_W-1:0] wiper,
  output logic              term_open
);
  logic sw_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wiper  <= MID_CODE;
      sw_off <= 1'b0;
    end else if (pin_rst) begin
      wiper  <= MID_CODE;
      sw_off <= 1'b0;
    end else if (wr_hit) begin
      wiper  <= code;
      sw_off <= 1'b0;
    end else if (off_hit) begin
      sw_off <= 1'b1;
    end
  end

  assign term_open = sw_off || hw_off;

  // R5
  hold_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hit && !pin_rst) |=> $stable(wiper));

  // R9
  pin_reset_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_rst |=> (wiper == MID_CODE && !sw_off));

  // R7
  write_wakes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !pin_rst) |=> (wiper == $past(code) && !sw_off));

  // R6
  shut_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (off_hit && !wr_hit && !pin_rst) |=> term_open);

  // R8
  hw_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_off |-> term_open);
endmodule

// File: rtl/digipot_ctrl.sv
module digipot_ctrl
  import digipot_pkg::*;
#(
  parameter int NCH = 2,
  localparam int WCW = NCH * CODE_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_n,
  input  logic           sck,
  input  logic           si,
  output logic           so,
  input  logic           rs_n,
  input  logic           shdn_n,
  output logic [WCW-1:0] wiper_code,
  output logic [NCH-1:0] term_a_open
);
  logic [1:0]          rs_m, sd_m;
  logic                pin_rst, hw_off;
  logic [FRAME_W-1:0]  frame;
  logic                commit_evt;
  logic [NCH-1:0]      wr_hit, off_hit;
  logic [CODE_W-1:0]   code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_m <= 2'b11;
      sd_m <= 2'b11;
    end else begin
      rs_m <= {rs_m[0], rs_n};
      sd_m <= {sd_m[0], shdn_n};
    end
  end

  assign pin_rst = !rs_m[1];
  assign hw_off  = !sd_m[1];

  serial_rx #(.FW(FRAME_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .so(so), .frame(frame), .commit_evt(commit_evt)
  );

  cmd_decode #(.NCH(NCH), .FW(FRAME_W)) u_dec (
    .frame(frame), .commit_evt(commit_evt),
    .wr_hit(wr_hit), .off_hit(off_hit), .code(code)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    wiper_chan u_chan (
      .clk(clk), .rst_n(rst_n), .pin_rst(pin_rst), .hw_off(hw_off),
      .wr_hit(wr_hit[i]), .off_hit(off_hit[i]), .code(code),
      .wiper(wiper_code[i*CODE_W +: CODE_W]), .term_open(term_a_open[i])
    );
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |-> (term_a_open == '0 || hw_off));
endmodule

// File: tb/digipot_ctrl_test.sv
module digipot_ctrl_test;
  localparam int NCH = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, rs_n = 1'b1, shdn_n = 1'b1;
  logic so;
  logic [15:0] wiper_code;
  logic [1:0]  term_a_open;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [7:0] m_w [2];
  logic [1:0] m_sw;
  logic       so_log [64];

  digipot_ctrl #(.NCH(NCH)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .so(so),
    .rs_n(rs_n), .shdn_n(shdn_n), .wiper_code(wiper_code), .term_a_open(term_a_open)
  );

  always #4 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_off();
    return m_sw | {2{~shdn_n}};
  endfunction

  // bench model of a closed frame
  function automatic void model(input int n, input logic [63:0] bits);
    logic [15:0] f;
    if (n == 0 || (n % 16) != 0 || !rs_n) return;
    f = bits[15:0];
    for (int c = 0; c < NCH; c++) begin
      if (f[8 + c]) begin
        if (f[13:12] == 2'b01) begin m_w[c] = f[7:0]; m_sw[c] = 1'b0; end
        else if (f[13:12] == 2'b10) m_sw[c] = 1'b1;
      end
    end
  endfunction

  task automatic send(input int n, input logic [63:0] bits, input bit idle_hi);
    sck = idle_hi; tick(4);
    cs_n = 1'b0; tick(4);
    for (int i = 0; i < n; i++) begin
      sck = 1'b0; si = bits[n-1-i]; tick(4);
      so_log[i] = so;
      sck = 1'b1; tick(4);
    end
    if (!idle_hi) begin sck = 1'b0; tick(4); end
    cs_n = 1'b1; tick(8);
    model(n, bits);
  endtask

  task automatic compare(input string req);
    chk(wiper_code == {m_w[1], m_w[0]}, req, wiper_code, {m_w[1], m_w[0]});
    chk(term_a_open == exp_off(), req, term_a_open, exp_off());
  endtask

  task automatic daisy_check(input int n, input logic [63:0] bits);
    logic [15:0] got;
    if (n != 32) return;
    for (int k = 0; k < 16; k++) got[15-k] = so_log[16+k];
    chk(got == bits[31:16], "R10", got, bits[31:16]);
  endtask

  function automatic logic [15:0] fr(input logic [1:0] op, input logic [1:0] sel, input logic [7:0] d);
    return {2'b00, op, 2'b00, sel, d};
  endfunction

  initial begin
    tick(1000 * 190);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] b;
    int n;
    m_w[0] = 8'h80; m_w[1] = 8'h80; m_sw = 2'b00;
    void'($urandom(32'd20240611));
    tick(5); rst_n = 1'b1; tick(3);
    compare("R1");

    send(16, 64'(fr(2'b01, 2'b01, 8'h00)), 0); compare("R5");
    send(16, 64'(fr(2'b01, 2'b10, 8'hFF)), 1); compare("R5 R2");
    send(16, 64'(fr(2'b01, 2'b11, 8'h5A)), 0); compare("R3");
    send(15, 64'(fr(2'b01, 2'b01, 8'h11)), 0); compare("R4 short");
    send(17, {47'd0, 1'b1, fr(2'b01, 2'b01, 8'h22)}, 1); compare("R4 long");
    b = {32'd0, fr(2'b01, 2'b01, 8'h33), fr(2'b01, 2'b10, 8'h44)};
    send(32, b, 0); compare("R4 multiple"); daisy_check(32, b);
    send(16, 64'(fr(2'b10, 2'b10, 8'h00)), 0); compare("R6");
    send(16, 64'(fr(2'b01, 2'b10, 8'h9C)), 1); compare("R7");
    send(16, 64'(fr(2'b00, 2'b11, 8'h01)), 0); compare("R11 op00");
    send(16, 64'(fr(2'b11, 2'b11, 8'h02)), 0); compare("R11 op11");
    send(16, 64'(fr(2'b10, 2'b01, 8'h00)), 0);
    shdn_n = 1'b0; tick(6); compare("R8 held");
    send(16, 64'(fr(2'b01, 2'b10, 8'h07)), 0); compare("R8 write");
    shdn_n = 1'b1; tick(6); compare("R8 release");
    rs_n = 1'b0; tick(6);
    m_w[0] = 8'h80; m_w[1] = 8'h80; m_sw = 2'b00;
    compare("R9 pin");
    send(16, 64'(fr(2'b01, 2'b11, 8'hEE)), 0); compare("R9 during");
    rs_n = 1'b1; tick(6); compare("R9 after");

    for (int it = 0; it < 200; it++) begin
      int r = $urandom % 8;
      b = {$urandom, $urandom};
      n = (r < 5) ? 16 : (r == 5) ? 32 : (r == 6) ? 1 + ($urandom % 31) : 48;
      if (($urandom % 10) == 0) begin shdn_n = ~shdn_n; tick(6); end
      if (($urandom % 20) == 0) begin
        rs_n = 1'b0; tick(6); rs_n = 1'b1; tick(6);
        m_w[0] = 8'h80; m_w[1] = 8'h80; m_sw = 2'b00;
      end
      send(n, b, $urandom % 2);
      compare("R3 R5 random");
      daisy_check(n, b);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule